// File: doc/BRIEF.md
# I2C 10-bit Target Address Matcher

This block is the address-recognition front end of an I2C target that answers to a 10-bit address. It watches the SCL and SDA lines, which are already synchronised to the system clock. It detects Start, Repeated Start and Stop conditions and shifts in the address bytes that follow a Start. It compares those bytes with a programmable 10-bit address under a 10-bit don't-care mask. When a byte is accepted, the block pulls SDA low for the acknowledge bit. It then updates its status flags and, if both interrupt enables are set, emits a one-cycle interrupt pulse.

A full match takes two bytes. The first byte carries the fixed prefix `11110`, the two upper address bits and a write direction bit. The second byte carries the lower eight address bits. After a full match, the target stays selected until the next Stop. A Repeated Start in that state needs only the prefix byte, in either direction, and the byte after it is data. Any byte that does not match makes the block leave SDA released and ignore the bus until the next Start.

Top module: `i2c10_addr_match`

## Requirements
- R1: The first byte after a Start from an unselected state is accepted only when its bits [7:3] are 11110 and its bit 0 (direction) is 0, meaning write.
- R2: Bits [2:1] of the first byte are compared with ownAddr[9:8] only at positions where addrMask[9:8] is 0. A mask bit of 1 means "don't care".
- R3: The second byte is compared bit by bit with ownAddr[7:0], skipping each position where addrMask[7:0] is 1.
- R4: For an accepted byte, sdaPullLow rises one clock after the falling SCL edge that ends bit 8 and falls one clock after the falling SCL edge that ends bit 9. It is 0 at all other times.
- R5: Accepting a prefix byte clears flagData. It also clears flagRead, except after a Repeated Start in the selected state (see R8).
- R6: Accepting the second byte sets flagAdd10, which stays set while the target is selected.
- R7: One clock after the falling SCL edge that ends the acknowledge of an accepted address byte, irqPulse is high for exactly one clock. This happens only if both addrIntEn and startIntEn are 1.
- R8: In the selected state, a Repeated Start followed by a matching prefix byte is acknowledged in either direction, and flagRead takes that byte's bit 0. The next byte is treated as data: it is not acknowledged, it sets flagData, and flagAdd10 stays set.
- R9: A byte that fails its comparison is not acknowledged. The block then deselects and ignores all bytes until the next Start.
- R10: A Stop clears flagAdd10 and the selected state, so a later Start needs the full two-byte match again.
- R11: After reset, sdaPullLow, flagAdd10, flagData, flagRead and irqPulse are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Synchronised SCL line level |
| sdaIn | input | 1 | Synchronised SDA line level |
| ownAddr | input | 10 | Programmed 10-bit target address |
| addrMask | input | 10 | Per-bit don't-care mask (1 = ignore bit) |
| addrIntEn | input | 1 | Address-match interrupt enable |
| startIntEn | input | 1 | Start interrupt enable |
| sdaPullLow | output | 1 | 1 = drive SDA low (acknowledge) |
| flagAdd10 | output | 1 | Full 10-bit address matched, target selected |
| flagData | output | 1 | Last byte received was data |
| flagRead | output | 1 | Direction of the last accepted prefix byte after a Repeated Start |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
On every cycle, the assertions check that the acknowledge only begins while SCL is low, right after a falling edge. They also check that each interrupt pulse lasts a single cycle, follows an SCL fall and has both enables behind it, that flagAdd10 only rises together with an acknowledge, and that a Stop always clears the selection. Only the bench scenarios can show the content of the comparison: the masked upper and lower compares, the rejection of a read direction or a wrong prefix, and the header-only match after a Repeated Start. The same holds for the flag histories across chains of Repeated Starts, and for the block ignoring later bytes after a rejection.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic ackSet;
    logic ackClr;
  } dpCtrl_t;

  // events and compare results from datapath to control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic byteDone;
    logic ackDone;
    logic hdrOk;
    logic lowOk;
    logic rwBit;
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_LOW,
    ST_LOW_ACK,
    ST_MATCHED
  } ctrlState_t;

endpackage

// File: rtl/i2c10_datapath.sv
module i2c10_datapath
  import i2c10_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int HDR_W  = 5,
  parameter logic [HDR_W-1:0] HDR_CODE = 5'b11110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  dpCtrl_t           ctl,
  output dpStat_t           stat,
  output logic              sdaPullLow
);

  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT   = CNT_W'(BYTE_W + 1);

  logic              sclQ, sdaQ;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              sclRise, sclFall;
  logic [HDR_W-1:0]  hdrField;
  logic [HI_W-1:0]   hiField;
  logic [HI_W-1:0]   hiDiff;
  logic [BYTE_W-1:0] loDiff;

  assign sclRise = sclIn & ~sclQ;
  assign sclFall = ~sclIn & sclQ;

  assign hdrField = shiftReg[BYTE_W-1 -: HDR_W];
  assign hiField  = shiftReg[HI_W:1];
  assign hiDiff   = (hiField ^ ownAddr[ADDR_W-1:BYTE_W]) & ~addrMask[ADDR_W-1:BYTE_W];
  assign loDiff   = (shiftReg ^ ownAddr[BYTE_W-1:0]) & ~addrMask[BYTE_W-1:0];

  always_comb begin
    stat.startEv  = sclIn & sclQ & sdaQ & ~sdaIn;
    stat.stopEv   = sclIn & sclQ & ~sdaQ & sdaIn;
    stat.byteDone = sclFall & (bitCnt == LAST_DATA);
    stat.ackDone  = sclFall & (bitCnt == ACK_BIT);
    stat.hdrOk    = (hdrField == HDR_CODE) && (hiDiff == '0);
    stat.lowOk    = (loDiff == '0);
    stat.rwBit    = shiftReg[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ       <= 1'b1;
      sdaQ       <= 1'b1;
      shiftReg   <= '0;
      bitCnt     <= '0;
      sdaPullLow <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (stat.startEv || stat.stopEv) begin
        bitCnt <= '0;
      end else if (sclRise && bitCnt != ACK_BIT) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
        bitCnt   <= bitCnt + 1'b1;
      end else if (stat.ackDone) begin
        bitCnt <= '0;
      end
      if (ctl.ackClr)      sdaPullLow <= 1'b0;
      else if (ctl.ackSet) sdaPullLow <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c10_ctrl.sv
module i2c10_ctrl
  import i2c10_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    addrIntEn,
  input  logic    startIntEn,
  output dpCtrl_t ctl,
  output logic    flagAdd10,
  output logic    flagData,
  output logic    flagRead,
  output logic    irqPulse
);

  ctrlState_t state;
  logic       selected;
  logic       hdrAccept;
  logic       lowAccept;

  assign hdrAccept = (state == ST_HDR) && stat.hdrOk && (selected || !stat.rwBit);
  assign lowAccept = (state == ST_LOW) && stat.lowOk;

  always_comb begin
    ctl.ackSet = stat.byteDone && (hdrAccept || lowAccept);
    ctl.ackClr = stat.ackDone || stat.startEv || stat.stopEv;
  end

  assign flagAdd10 = selected;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      selected <= 1'b0;
      flagData <= 1'b0;
      flagRead <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= 1'b0;
      if (stat.stopEv) begin
        state    <= ST_IDLE;
        selected <= 1'b0;
      end else if (stat.startEv) begin
        state <= ST_HDR;
      end else begin
        unique case (state)
          ST_HDR: if (stat.byteDone) begin
            if (hdrAccept) begin
              state    <= ST_HDR_ACK;
              flagData <= 1'b0;
              flagRead <= selected ? stat.rwBit : 1'b0;
            end else begin
              state    <= ST_IDLE;
              selected <= 1'b0;
            end
          end
          ST_HDR_ACK: if (stat.ackDone) begin
            irqPulse <= addrIntEn & startIntEn;
            state    <= selected ? ST_MATCHED : ST_LOW;
          end
          ST_LOW: if (stat.byteDone) begin
            if (lowAccept) begin
              state    <= ST_LOW_ACK;
              selected <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_LOW_ACK: if (stat.ackDone) begin
            irqPulse <= addrIntEn & startIntEn;
            state    <= ST_MATCHED;
          end
          ST_MATCHED: if (stat.byteDone) flagData <= 1'b1;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
  import i2c10_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic              addrIntEn,
  input  logic              startIntEn,
  output logic              sdaPullLow,
  output logic              flagAdd10,
  output logic              flagData,
  output logic              flagRead,
  output logic              irqPulse
);

  dpCtrl_t ctl;
  dpStat_t stat;

  i2c10_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .addrMask(addrMask), .ctl(ctl), .stat(stat),
    .sdaPullLow(sdaPullLow)
  );

  i2c10_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .addrIntEn(addrIntEn),
    .startIntEn(startIntEn), .ctl(ctl), .flagAdd10(flagAdd10),
    .flagData(flagData), .flagRead(flagRead), .irqPulse(irqPulse)
  );

endmodule

// File: rtl/i2c10_addr_match_chk.sv
module i2c10_addr_match_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic addrIntEn,
  input logic startIntEn,
  input logic sdaPullLow,
  input logic flagAdd10,
  input logic irqPulse
);

  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn && !$past(sclIn) && $past(sclIn, 2)); // R4

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(addrIntEn) && $past(startIntEn)); // R7

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R7

  AST_IRQ_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !sclIn && !sdaPullLow); // R7

  AST_ADD10_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagAdd10) |-> sdaPullLow); // R6

  AST_STOP_DESELECTS: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && sdaIn && !$past(sdaIn)) |=> !flagAdd10 && !sdaPullLow); // R10

endmodule

bind i2c10_addr_match i2c10_addr_match_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .addrIntEn(addrIntEn), .startIntEn(startIntEn), .sdaPullLow(sdaPullLow),
  .flagAdd10(flagAdd10), .irqPulse(irqPulse)
);

// File: tb/test_i2c10_addr_match.sv
module test_i2c10_addr_match;

  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 6;
  localparam int  NVEC = 11;

  // {ownAddr, addrMask, byte1, byte2, expAck1, expAck2}
  localparam logic [37:0] VEC [NVEC] = '{
    {10'h2A5, 10'h000, 8'hF4, 8'hA5, 1'b1, 1'b1},
    {10'h2A5, 10'h000, 8'hF4, 8'hA4, 1'b1, 1'b0},
    {10'h2A5, 10'h000, 8'hF6, 8'hA5, 1'b0, 1'b0},
    {10'h2A5, 10'h300, 8'hF2, 8'hA5, 1'b1, 1'b1},
    {10'h2A5, 10'h001, 8'hF4, 8'hA4, 1'b1, 1'b1},
    {10'h2A5, 10'h000, 8'hF5, 8'hA5, 1'b0, 1'b0},
    {10'h2A5, 10'h000, 8'hE4, 8'hA5, 1'b0, 1'b0},
    {10'h2A5, 10'h0FF, 8'hF4, 8'h00, 1'b1, 1'b1},
    {10'h2A5, 10'h100, 8'hF6, 8'hA5, 1'b1, 1'b1},
    {10'h2A5, 10'h200, 8'hF6, 8'hA5, 1'b0, 1'b0},
    {10'h3C0, 10'h03C, 8'hF6, 8'hC3, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       hostSda = 1'b1;
  logic       sdaBus;
  logic [9:0] ownAddr = 10'h2A5;
  logic [9:0] addrMask = 10'h000;
  logic       addrIntEn = 1'b1;
  logic       startIntEn = 1'b1;
  logic       sdaPullLow, flagAdd10, flagData, flagRead, irqPulse;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  bit finished = 1'b0;

  assign sdaBus = hostSda & ~sdaPullLow;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (irqPulse) irqCount++;

  i2c10_addr_match i_i2c10_addr_match (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaBus),
    .ownAddr(ownAddr), .addrMask(addrMask), .addrIntEn(addrIntEn),
    .startIntEn(startIntEn), .sdaPullLow(sdaPullLow), .flagAdd10(flagAdd10),
    .flagData(flagData), .flagRead(flagRead), .irqPulse(irqPulse)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    hostSda = 1'b1; waitCyc(HALF);
    sclLine = 1'b1; waitCyc(HALF);
    hostSda = 1'b0; waitCyc(HALF);
    sclLine = 1'b0; waitCyc(HALF);
  endtask

  task automatic busStop();
    hostSda = 1'b0; waitCyc(HALF);
    sclLine = 1'b1; waitCyc(HALF);
    hostSda = 1'b1; waitCyc(HALF);
  endtask

  task automatic sendBit(input logic b, output logic lineVal);
    hostSda = b;     waitCyc(HALF);
    sclLine = 1'b1;  waitCyc(HALF);
    lineVal = sdaBus;
    sclLine = 1'b0;  waitCyc(HALF);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic lv;
    for (int i = 7; i >= 0; i--) sendBit(v[i], lv);
    sendBit(1'b1, lv);
    acked = ~lv;
  endtask

  initial begin
    logic a1, a2, lv;
    int irq0;
    waitCyc(5);
    // R11: reset state
    chk("R11 sdaPullLow", sdaPullLow, 0);
    chk("R11 flagAdd10", flagAdd10, 0);
    chk("R11 flagData", flagData, 0);
    chk("R11 flagRead", flagRead, 0);
    chk("R11 irqPulse", irqPulse, 0);
    rstN = 1'b1;
    waitCyc(5);

    // vector table: R1 R2 R3 R6 R7 R9 R10
    for (int k = 0; k < NVEC; k++) begin
      ownAddr  = VEC[k][37:28];
      addrMask = VEC[k][27:18];
      irq0 = irqCount;
      busStart();
      sendByte(VEC[k][17:10], a1);
      chk($sformatf("R1/R2 vec%0d first ack", k), a1, VEC[k][1]);
      if (VEC[k][1]) chk($sformatf("R5 vec%0d flags", k), {flagData, flagRead}, 0);
      sendByte(VEC[k][9:2], a2);
      chk($sformatf("R3/R9 vec%0d second ack", k), a2, VEC[k][0]);
      chk($sformatf("R6 vec%0d flagAdd10", k), flagAdd10, VEC[k][0]);
      chk($sformatf("R7 vec%0d irq count", k), irqCount - irq0, VEC[k][1] + VEC[k][0]);
      busStop();
      chk($sformatf("R10 vec%0d cleared by stop", k), flagAdd10, 0);
    end
    ownAddr = 10'h2A5;
    addrMask = 10'h000;

    // R7: interrupt needs both enables
    addrIntEn = 1'b1; startIntEn = 1'b0;
    irq0 = irqCount;
    busStart(); sendByte(8'hF4, a1); sendByte(8'hA5, a2); busStop();
    chk("R7 no irq without start enable", irqCount - irq0, 0);
    addrIntEn = 1'b0; startIntEn = 1'b1;
    busStart(); sendByte(8'hF4, a1); sendByte(8'hA5, a2); busStop();
    chk("R7 no irq without address enable", irqCount - irq0, 0);
    chk("R6 matched with irq disabled", {a1, a2}, 2'b11);
    addrIntEn = 1'b1; startIntEn = 1'b1;

    // R8: repeated start keeps selection, header-only match
    busStart(); sendByte(8'hF4, a1); sendByte(8'hA5, a2);
    sendByte(8'h3C, a1);
    chk("R8 data byte not acked", a1, 0);
    chk("R8 data flag set", flagData, 1);
    irq0 = irqCount;
    busStart(); sendByte(8'hF5, a1);
    chk("R8 read header acked after restart", a1, 1);
    chk("R8 read flag from header", flagRead, 1);
    chk("R5 data flag cleared by header", flagData, 0);
    chk("R8 add10 kept", flagAdd10, 1);
    chk("R7 irq on restart header", irqCount - irq0, 1);
    sendByte(8'hA5, a2);
    chk("R8 next byte treated as data", a2, 0);
    chk("R8 data flag after restart", flagData, 1);
    busStart(); sendByte(8'hF4, a1);
    chk("R8 write header acked after restart", a1, 1);
    chk("R5 read flag cleared", flagRead, 0);
    busStop();
    chk("R10 stop clears add10", flagAdd10, 0);
    busStart(); sendByte(8'hF5, a1);
    chk("R10 read header refused after stop", a1, 0);
    busStop();

    // R9: ignore until next start after a reject
    busStart(); sendByte(8'hF6, a1);
    chk("R9 wrong header nacked", a1, 0);
    sendByte(8'hF4, a1);
    chk("R9 header ignored after reject", a1, 0);
    sendByte(8'hA5, a2);
    chk("R9 low byte ignored after reject", a2, 0);
    chk("R9 not selected", flagAdd10, 0);
    busStart(); sendByte(8'hF4, a1);
    chk("R9 new start accepted again", a1, 1);
    busStop();

    // R4: acknowledge window
    busStart();
    for (int i = 7; i >= 1; i--) sendBit(1'(8'hF4 >> i), lv);
    hostSda = 1'b0; waitCyc(HALF);
    sclLine = 1'b1; waitCyc(HALF);
    chk("R4 released during bit 8", sdaPullLow, 0);
    sclLine = 1'b0; waitCyc(2);
    chk("R4 driven after bit 8 fall", sdaPullLow, 1);
    waitCyc(HALF - 2);
    sendBit(1'b1, lv);
    chk("R4 acked bit 9", lv, 0);
    chk("R4 released after bit 9", sdaPullLow, 0);
    busStop();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule